// File: doc/BRIEF.md
# Serial Configuration Port with Strap-Loaded Defaults

This block is a serial slave that gives a host read and write access to a small bank of 8-bit configuration registers, using four wires: an active-low select, a serial clock, data in and data out. The serial pins are sampled by the block's own system clock, so all register state lives in a single clock domain. A static edge-select input chooses whether read data on the data-out pin moves on falling or on rising serial clock edges. This lets the port serve hosts that sample on either edge.

While the synchronous reset is held, the block samples a 3-bit frequency strap and a one-bit network-type strap on each clock edge. It decodes them into a 4-bit frequency code and loads that code into the expected-frequency registers of both clock inputs, so both start out identical. The network-type strap gives the initial value of a mode bit. Software may overwrite all of these registers later. The straps are not read outside reset, and every new reset restores the strap-derived values. A parallel read-out bus shows any register's contents to the surrounding logic.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rst_n` is low, register 0x00 (input A expected frequency) and register 0x01 (input B expected frequency) both load `{4'b0000, code}`. Register 0x02 (mode) loads `{7'b0, strap_sonet}`, where 1 means SONET and 0 means SDH. Every other register loads 0x00.
- R2: The 4-bit strap word `{strap_freq[2:0], strap_sonet}` decodes to a code as follows. `000x` gives 0 (8 kHz). `0010` gives 1 (2.048 MHz). `0011` gives 2 (1.544 MHz). `010x` gives 3 (6.48 MHz). `011x` gives 4 (19.44 MHz). `100x` gives 5 (25.92 MHz). `101x` gives 6 (38.88 MHz). `110x` gives 7 (51.84 MHz). `111x` gives 8 (77.76 MHz).
- R3: After reset is released, changes on `strap_freq` or `strap_sonet` leave every register unchanged.
- R4: A later reset overwrites values that software wrote with the strap-derived values of R1.
- R5: A frame consists of 16 bits, each captured on a rising `sck` edge with the most significant bit first. The bits are a direction bit (1 = read, 0 = write), a 7-bit register address and 8 data bits. A write takes effect only once the 16th bit has been captured, and it may change any in-range register, including the mode register.
- R6: While `cs_n` is high, `sck` and `mosi` activity has no effect. Raising `cs_n` before the 16th bit aborts the frame without a write, and the next frame starts again at the direction bit.
- R7: In a read frame with `edge_sel` = 1, data bit 7 appears on the falling edge that follows the last address bit. Each following bit appears on the next falling edge, and `miso` never changes on a rising edge. With `edge_sel` = 0, data bit 7 appears on the rising edge that captures the last address bit. Each following bit appears on the next rising edge, and `miso` never changes on a falling edge.
- R8: Writes to addresses 0x10 and above change no register, and serial reads from those addresses return 0x00.
- R9: `miso` is 0 whenever `cs_n` is high and throughout a write frame.
- R10: `rd_data` shows the contents of the register at `rd_addr` combinationally, and shows 0x00 when `rd_addr` is 0x10 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset; straps are loaded while it is low |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial read data out of the block |
| edge_sel | input | 1 | 1: read data moves on falling `sck`; 0: on rising `sck` |
| strap_freq | input | 3 | Frequency strap, used only during reset |
| strap_sonet | input | 1 | Network-type strap, used only during reset |
| rd_addr | input | 7 | Parallel read-out address |
| rd_data | output | 8 | Parallel read-out data |

## Verification
The hardest case to reach from the ports is the timing of `miso` relative to the serial clock edge that edge-select does not choose. The output must hold across that edge while the synchronizer delay moves the real update several system cycles behind the chosen edge. The bench therefore samples `miso` just before every rising and every falling `sck` edge of each read frame, in both edge-select settings. It requires the value to stay the same across the edge that is not chosen, and it assembles the received byte from the samples that the host's side would use. Aborted frames and clocking while deselected are each followed by a complete write and read-back, which shows that the bit count restarted at the direction bit.

// File: rtl/cfgp_pkg.sv
// Package: shared constants and the strap decode for the serial configuration port.
// Assumes: 8-bit registers, 7-bit register addresses, 4-bit frequency codes.
package cfgp_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int CODE_W    = 4;

    // Register addresses that carry strap-derived defaults
    localparam int FREQ_A_ADDR = 0;
    localparam int FREQ_B_ADDR = 1;
    localparam int MODE_ADDR   = 2;

    // Frequency codes stored in the low bits of the expected-frequency registers
    localparam logic [CODE_W-1:0] CODE_8K     = 4'd0;
    localparam logic [CODE_W-1:0] CODE_2M048  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_1M544  = 4'd2;

    // Maps the frequency strap and network-type strap onto a frequency code
    function automatic logic [CODE_W-1:0] strap_to_code(input logic [2:0] fsel,
                                                        input logic       sonet);
        logic [CODE_W-1:0] code;
        case (fsel)
            3'd0:    code = CODE_8K;
            3'd1:    code = sonet ? CODE_1M544 : CODE_2M048;
            default: code = {1'b0, fsel} + 4'd1;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/cfgp_pin_sync.sv
// Module: multi-stage synchronizer for a group of slow asynchronous pins.
// Assumes: each pin is stable for several clk periods between changes, so the
// bits of the group may be treated independently.
module cfgp_pin_sync #(
    parameter int                 WIDTH     = 4,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each pin one stage further toward the clk domain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RESET_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= pins_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign pins_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfgp_frame.sv
// Module: serial frame decoder. It detects sck edges in the clk domain,
// counts bits, assembles the direction, address and data fields, and says
// when read data must be loaded and when each output bit must be launched.
// Assumes: sck is slower than clk/6 and idle low; the frame is a direction bit,
// then ADDR_W address bits, then DATA_W data bits, MSB first.
module cfgp_frame #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        sck,
    input  logic                        mosi,
    input  logic                        edge_sel,
    output logic                        cs_idle,
    output logic                        load,
    output logic [ADDR_W-1:0]           hdr_addr,
    output logic                        launch,
    output logic [$clog2(DATA_W)-1:0]   launch_idx,
    output logic                        wr_en,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [DATA_W-1:0]           wr_data
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int IDX_W      = $clog2(DATA_W);
    localparam int SH_W       = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_PREV = CNT_W'(FRAME_BITS - 2);
    localparam logic [CNT_W-1:0] FRAME_DONE = CNT_W'(FRAME_BITS);

    logic [3:0]        pins_s;
    logic              sck_s, cs_n_s, mosi_s, edge_s;
    logic              sck_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SH_W-1:0]   shift_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              rise, fall;

    cfgp_pin_sync #(
        .WIDTH     (4),
        .STAGES    (STAGES),
        .RESET_VAL (4'b0010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  ({edge_sel, mosi, cs_n, sck}),
        .pins_out (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[2];
    assign edge_s = pins_s[3];

    assign cs_idle = cs_n_s;
    assign rise    = !cs_n_s && sck_s && !sck_d;
    assign fall    = !cs_n_s && !sck_s && sck_d;

    // Track the previous synchronized sck level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Count captured bits and shift in data; restart whenever select is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
            addr_q  <= '0;
            rw_q    <= 1'b0;
        end else if (cs_n_s) begin
            cnt_q   <= '0;
        end else if (rise && cnt_q != FRAME_DONE) begin
            cnt_q   <= cnt_q + 1'b1;
            shift_q <= {shift_q[SH_W-2:0], mosi_s};
            if (cnt_q == HDR_LAST) begin
                addr_q <= {shift_q[ADDR_W-2:0], mosi_s};
                rw_q   <= shift_q[ADDR_W-1];
            end
        end
    end

    // Header completion: address is known, a read must fetch its byte now
    assign hdr_addr = {shift_q[ADDR_W-2:0], mosi_s};
    assign load     = rise && (cnt_q == HDR_LAST) && shift_q[ADDR_W-1];

    // Write strobe once the final data bit has been captured
    assign wr_en   = rise && (cnt_q == FRAME_LAST) && !rw_q;
    assign wr_addr = addr_q;
    assign wr_data = {shift_q[DATA_W-2:0], mosi_s};

    // Launch points for output bits on the edge chosen by edge_sel
    always_comb begin
        launch     = 1'b0;
        launch_idx = '0;
        if (edge_s) begin
            if (fall && cnt_q >= DATA_FIRST && cnt_q <= FRAME_LAST) begin
                launch     = 1'b1;
                launch_idx = IDX_W'(FRAME_LAST - cnt_q);
            end
        end else begin
            if (rise && cnt_q >= HDR_LAST && cnt_q <= FRAME_PREV) begin
                launch     = 1'b1;
                launch_idx = IDX_W'(FRAME_PREV - cnt_q);
            end
        end
    end

endmodule

// File: rtl/cfgp_regfile.sv
// Module: configuration register bank with strap-loaded defaults.
// Assumes: straps are stable while rst_n is low and clk is running; outside
// reset the straps are not looked at. Out-of-range accesses are dropped/read 0.
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap_freq,
    input  logic              strap_sonet,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] sr_addr,
    output logic [DATA_W-1:0] sr_data,
    input  logic [ADDR_W-1:0] pr_addr,
    output logic [DATA_W-1:0] pr_data
);

    localparam int RIDX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [CODE_W-1:0] strap_code;
    logic              wr_in_range;
    logic [RIDX_W-1:0] widx;

    assign strap_code  = strap_to_code(strap_freq, strap_sonet);
    assign wr_in_range = int'(wr_addr) < NUM_REGS;
    assign widx        = wr_addr[RIDX_W-1:0];

    // Default value for one register, derived from the straps
    function automatic logic [DATA_W-1:0] default_of(input int idx,
                                                     input logic [CODE_W-1:0] code,
                                                     input logic sonet);
        if (idx == FREQ_A_ADDR || idx == FREQ_B_ADDR)
            return DATA_W'(code);
        else if (idx == MODE_ADDR)
            return DATA_W'(sonet);
        else
            return '0;
    endfunction

    // Register storage: strap defaults during reset, serial writes afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs[i] <= default_of(i, strap_code, strap_sonet);
        end else if (wr_en && wr_in_range) begin
            regs[widx] <= wr_data;
        end
    end

    // Read port for the serial side
    always_comb begin
        if (int'(sr_addr) < NUM_REGS) sr_data = regs[sr_addr[RIDX_W-1:0]];
        else                          sr_data = '0;
    end

    // Read port for the parallel read-out bus
    always_comb begin
        if (int'(pr_addr) < NUM_REGS) pr_data = regs[pr_addr[RIDX_W-1:0]];
        else                          pr_data = '0;
    end

    // Both frequency registers leave reset equal, mode bit follows its strap
    assert_strap_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs[FREQ_A_ADDR] == regs[FREQ_B_ADDR]) &&
                         (regs[MODE_ADDR] == DATA_W'($past(strap_sonet))));

    // A completed in-range write lands in the addressed register
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_in_range) |=> regs[$past(widx)] == $past(wr_data));

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_hold
            // Without a write addressed to it a register holds (straps included)
            assert_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_in_range && widx == RIDX_W'(g)) |=> $stable(regs[g]));
        end
    endgenerate

endmodule

// File: rtl/cfgp_tx.sv
// Module: read-data output stage. It holds the byte fetched at header end and
// presents the bit selected by the most recent launch on miso.
// Assumes: at most one load per frame; cs_idle clears all state.
module cfgp_tx #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_idle,
    input  logic                      load,
    input  logic [DATA_W-1:0]         load_data,
    input  logic                      launch,
    input  logic [$clog2(DATA_W)-1:0] launch_idx,
    output logic                      miso
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] tx_buf;
    logic [IDX_W-1:0]  out_idx;
    logic              armed;
    logic              out_valid;

    // Capture the read byte and step through its bits at launch points
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            tx_buf    <= '0;
            out_idx   <= '0;
            armed     <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            if (load) begin
                tx_buf <= load_data;
                armed  <= 1'b1;
            end
            if (launch && (armed || load)) begin
                out_idx   <= launch_idx;
                out_valid <= 1'b1;
            end
        end
    end

    assign miso = out_valid && tx_buf[out_idx];

    // Within a frame, miso moves only after a launch on the chosen edge
    assert_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_idle && !$past(cs_idle) && (miso != $past(miso))) |-> $past(launch));

    // Deselected port keeps miso low
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_idle && $past(cs_idle)) |-> !miso);

endmodule

// File: rtl/cfg_serial_port.sv
// Module: top of the serial configuration port. It ties the frame decoder, the
// register bank and the output stage together.
// Assumes: serial pins are asynchronous to clk and much slower than clk.
module cfg_serial_port #(
    parameter int ADDR_W   = cfgp_pkg::ADDR_W,
    parameter int DATA_W   = cfgp_pkg::DATA_W,
    parameter int NUM_REGS = 16,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    input  logic              edge_sel,
    input  logic [2:0]        strap_freq,
    input  logic              strap_sonet,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(DATA_W);

    logic              cs_idle, load, launch, wr_en;
    logic [ADDR_W-1:0] hdr_addr, wr_addr;
    logic [DATA_W-1:0] wr_data, sr_data;
    logic [IDX_W-1:0]  launch_idx;

    cfgp_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAGES (STAGES)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .edge_sel   (edge_sel),
        .cs_idle    (cs_idle),
        .load       (load),
        .hdr_addr   (hdr_addr),
        .launch     (launch),
        .launch_idx (launch_idx),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    cfgp_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_freq  (strap_freq),
        .strap_sonet (strap_sonet),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sr_addr     (hdr_addr),
        .sr_data     (sr_data),
        .pr_addr     (rd_addr),
        .pr_data     (rd_data)
    );

    cfgp_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_idle    (cs_idle),
        .load       (load),
        .load_data  (sr_data),
        .launch     (launch),
        .launch_idx (launch_idx),
        .miso       (miso)
    );

endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;

    localparam int H = 6; // clk cycles per sck half period

    // Strap word {freq[2:0], sonet} in the high nibble, expected code in the low nibble
    localparam logic [7:0] VEC [16] = '{
        8'h00, 8'h10, 8'h21, 8'h32, 8'h43, 8'h53, 8'h64, 8'h74,
        8'h85, 8'h95, 8'hA6, 8'hB6, 8'hC7, 8'hD7, 8'hE8, 8'hF8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       edge_sel = 1'b1;
    logic [2:0] strap_freq = 3'd0;
    logic       strap_sonet = 1'b0;
    logic [6:0] rd_addr = 7'd0;
    logic       miso;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cfg_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .edge_sel(edge_sel), .strap_freq(strap_freq),
        .strap_sonet(strap_sonet), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] f, input logic s);
        strap_freq  = f;
        strap_sonet = s;
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic peek(input logic [6:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Drives nbits of a frame; returns the received byte, whether miso stayed put
    // across the edge not chosen, and whether miso was ever high
    task automatic frame(input logic rw, input logic [6:0] a, input logic [7:0] wd,
                         input int nbits, output logic [7:0] rd,
                         output logic order_ok, output logic any_high);
        logic [15:0] bits;
        logic v_rise, v_fall, prev_fall;
        bits = {rw, a, wd};
        rd = 8'h00;
        order_ok = 1'b1;
        any_high = 1'b0;
        prev_fall = 1'b0;
        cs_n = 1'b0;
        wait_clk(H);
        for (int b = 0; b < nbits; b++) begin
            mosi = bits[15-b];
            wait_clk(H);
            v_rise = miso;
            sck = 1'b1;
            wait_clk(H);
            v_fall = miso;
            any_high = any_high | v_rise | v_fall;
            if (edge_sel) begin
                if (b >= 8) begin
                    rd[15-b] = v_rise;
                    if (v_rise != v_fall) order_ok = 1'b0;
                end
            end else begin
                if (b >= 7 && b <= 14) rd[14-b] = v_fall;
                if (b >= 8 && b <= 14 && v_rise != prev_fall) order_ok = 1'b0;
            end
            prev_fall = v_fall;
            sck = 1'b0;
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2*H);
    endtask

    initial begin
        logic [7:0] v, r;
        logic ok, hi;

        // Strap vector table: reset defaults and decode (R1, R2)
        for (int i = 0; i < 16; i++) begin
            do_reset(VEC[i][7:5], VEC[i][4]);
            peek(7'h00, v); check("R2 freq A code", v, {4'h0, VEC[i][3:0]});
            peek(7'h01, v); check("R1 freq B code", v, {4'h0, VEC[i][3:0]});
            peek(7'h02, v); check("R1 mode bit", v, {7'd0, VEC[i][4]});
            peek(7'h07, v); check("R1 plain reg zero", v, 0);
        end

        do_reset(3'b011, 1'b0);
        check("R9 miso low when idle", miso, 0);

        // Serial write, seen on the parallel bus (R5, R10)
        edge_sel = 1'b0;
        frame(1'b0, 7'h05, 8'hA5, 16, r, ok, hi);
        peek(7'h05, v); check("R5 write via serial", v, 8'hA5);
        check("R9 miso low during write", hi, 0);

        // Read back with output on rising edges (R7)
        frame(1'b1, 7'h05, 8'h00, 16, r, ok, hi);
        check("R7 rising-edge read data", r, 8'hA5);
        check("R7 no change on falling", ok, 1);

        // Read back with output on falling edges (R7)
        edge_sel = 1'b1;
        frame(1'b1, 7'h05, 8'h00, 16, r, ok, hi);
        check("R7 falling-edge read data", r, 8'hA5);
        check("R7 no change on rising", ok, 1);
        frame(1'b1, 7'h00, 8'h00, 16, r, ok, hi);
        check("R5 serial read of freq A", r, 8'h04);

        // Mode bit writable by software (R5)
        frame(1'b0, 7'h02, 8'h01, 16, r, ok, hi);
        peek(7'h02, v); check("R5 mode written", v, 8'h01);

        // Straps change without reset (R3)
        strap_freq = 3'b111; strap_sonet = 1'b1;
        wait_clk(10);
        peek(7'h00, v); check("R3 freq A unchanged", v, 8'h04);
        peek(7'h01, v); check("R3 freq B unchanged", v, 8'h04);
        frame(1'b1, 7'h01, 8'h00, 16, r, ok, hi);
        check("R3 serial freq B unchanged", r, 8'h04);

        // Software value then reset reloads straps (R4)
        frame(1'b0, 7'h00, 8'h3C, 16, r, ok, hi);
        peek(7'h00, v); check("R4 software value present", v, 8'h3C);
        do_reset(3'b001, 1'b1);
        peek(7'h00, v); check("R4 freq A reloaded", v, 8'h02);
        peek(7'h02, v); check("R4 mode reloaded", v, 8'h01);

        // Clocking while deselected, then aborted frame (R6)
        frame(1'b0, 7'h05, 8'h5A, 16, r, ok, hi);
        for (int k = 0; k < 20; k++) begin
            mosi = k[0];
            sck = 1'b1; wait_clk(H);
            sck = 1'b0; wait_clk(H);
        end
        peek(7'h05, v); check("R6 sck ignored while deselected", v, 8'h5A);
        frame(1'b0, 7'h05, 8'hFF, 12, r, ok, hi);
        peek(7'h05, v); check("R6 aborted frame no write", v, 8'h5A);
        frame(1'b0, 7'h06, 8'h81, 16, r, ok, hi);
        peek(7'h06, v); check("R6 frame realigned after abort", v, 8'h81);

        // Out-of-range accesses (R8, R10)
        frame(1'b0, 7'h40, 8'hFF, 16, r, ok, hi);
        peek(7'h05, v); check("R8 reg 5 untouched", v, 8'h5A);
        peek(7'h00, v); check("R8 reg 0 untouched", v, 8'h02);
        peek(7'h40, v); check("R10 bus out of range reads 0", v, 0);
        frame(1'b1, 7'h40, 8'h00, 16, r, ok, hi);
        check("R8 serial out of range reads 0", r, 0);
        check("R8 miso stays low", hi, 0);
        check("R9 miso low after frame", miso, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule